// File: doc/BRIEF.md
# External Bus Cycle Sequencer

This block runs the control side of external memory cycles on a 16-bit data bus. The CPU side offers one access at a time through a valid/ready handshake. Each access carries a direction, a size (byte, halfword or word), the low address bit and a wait-state count. Once the sequencer accepts an access, it steps through a fixed series of states. It drives two active-low byte-lane enables, a read/write status line and an active-low data strobe. It also flags the clock in which the data transfer completes.

The sequencer states are `ST_IDLE`, `ST_T1`, `ST_T2` and `ST_TW`. An accepted request moves `ST_IDLE` to `ST_T1`. `ST_T1` always moves to `ST_T2`. `ST_T2` moves to `ST_TW` while wait states remain, and `ST_TW` loops on itself until they run out. The final `ST_T2` or `ST_TW` returns to `ST_IDLE`. If a new request is accepted in that same final clock, the sequencer instead moves straight to `ST_T1`.

The lane enables and the status line are loaded on the clock edge that enters `ST_T1`. The strobe covers the data phase only.

Top module: `bus_cycle_ctrl`

## Requirements
- R1: After reset, `ube_n`, `lbe_n`, `rd_wr` and `dstb_n` are all 1, `req_ready` is 1 and `xfer_done` is 0.
- R2: For a halfword access (`req_size`=01), a word access (10) or the reserved code (11), both `ube_n` and `lbe_n` are driven 0 for the cycle.
- R3: For a byte access (`req_size`=00), `req_addr0`=0 gives `ube_n`=1 and `lbe_n`=0. `req_addr0`=1 gives `ube_n`=0 and `lbe_n`=1.
- R4: `ube_n`, `lbe_n` and `rd_wr` take their new values only on the edge that accepts a request. The lane enables keep the last cycle's values through idle clocks.
- R5: `rd_wr` is 1 for a read (`req_write`=0) and 0 for a write (`req_write`=1) from `ST_T1` to the end of the cycle. It is 1 in every idle clock.
- R6: `dstb_n` is 0 in `ST_T2` and in every `ST_TW` clock. It is 1 in `ST_T1` and in `ST_IDLE`.
- R7: An accepted cycle spends one clock in `ST_T1`, one clock in `ST_T2` and then exactly `req_wait` clocks in `ST_TW`.
- R8: `xfer_done` is 1 for exactly one clock, the final `ST_T2` or `ST_TW` of a cycle.
- R9: `req_ready` is 1 only in `ST_IDLE` and in the final state of a cycle. A request presented at any other time is held off and leaves the outputs unchanged.
- R10: A request accepted in the final state of a cycle starts its `ST_T1` in the very next clock, with no idle clock between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request offered |
| req_ready | output | 1 | Sequencer can take a request this clock |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 00 byte, 01 halfword, 10 word, 11 treated as word |
| req_addr0 | input | 1 | Low address bit of the access |
| req_wait | input | WAIT_W | Number of wait states to insert |
| ube_n | output | 1 | Upper byte lane enable, active low |
| lbe_n | output | 1 | Lower byte lane enable, active low |
| rd_wr | output | 1 | Bus status: 1 read or idle, 0 write |
| dstb_n | output | 1 | Data strobe, active low |
| xfer_done | output | 1 | Data transfer completes this clock |

## Verification
The bench builds the block with the default `WAIT_W` of 3. Every wait count from zero up to the maximum of seven can therefore be reached, and the table includes both ends of that range. With the narrow counter, a cycle that runs through all the wait states stays short. This leaves room for directed cases: a request held off during a busy cycle, and back-to-back cycles joined at the final state.

// File: rtl/bcc_pkg.sv
package bcc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_T1   = 2'b01,
        ST_T2   = 2'b10,
        ST_TW   = 2'b11
    } bus_state_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_RSVD = 2'b11
    } acc_size_e;

    typedef struct packed {
        logic ube_n;
        logic lbe_n;
    } lane_en_t;

endpackage

// File: rtl/bcc_seq.sv
module bcc_seq
    import bcc_pkg::*;
#(
    parameter int WAIT_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [WAIT_W-1:0] req_wait,
    output bus_state_e        state_q,
    output bus_state_e        state_d,
    output logic              req_ready,
    output logic              accept,
    output logic              last
);

    logic [WAIT_W-1:0] cnt_q;
    logic [WAIT_W-1:0] cnt_d;

    always_comb begin
        last      = ((state_q == ST_T2) || (state_q == ST_TW)) && (cnt_q == '0);
        req_ready = (state_q == ST_IDLE) || last;
        accept    = req_valid && req_ready;
        state_d   = state_q;
        cnt_d     = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    state_d = ST_T1;
                    cnt_d   = req_wait;
                end
            end
            ST_T1: begin
                state_d = ST_T2;
            end
            ST_T2, ST_TW: begin
                if (cnt_q != '0) begin
                    state_d = ST_TW;
                    cnt_d   = cnt_q - WAIT_W'(1);
                end else if (accept) begin
                    state_d = ST_T1;
                    cnt_d   = req_wait;
                end else begin
                    state_d = ST_IDLE;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

endmodule

// File: rtl/bcc_lane_dec.sv
module bcc_lane_dec
    import bcc_pkg::*;
(
    input  logic [1:0] size,
    input  logic       addr0,
    output lane_en_t   lanes
);

    always_comb begin
        unique case (acc_size_e'(size))
            SZ_BYTE: begin
                lanes.ube_n = ~addr0;
                lanes.lbe_n = addr0;
            end
            SZ_HALF, SZ_WORD, SZ_RSVD: begin
                lanes.ube_n = 1'b0;
                lanes.lbe_n = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/bcc_out_reg.sv
module bcc_out_reg
    import bcc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       accept,
    input  logic       req_write,
    input  lane_en_t   lanes,
    input  bus_state_e state_d,
    output logic       ube_n,
    output logic       lbe_n,
    output logic       rd_wr,
    output logic       dstb_n
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ube_n  <= 1'b1;
            lbe_n  <= 1'b1;
            rd_wr  <= 1'b1;
            dstb_n <= 1'b1;
        end else begin
            if (accept) begin
                ube_n <= lanes.ube_n;
                lbe_n <= lanes.lbe_n;
                rd_wr <= ~req_write;
            end else if (state_d == ST_IDLE) begin
                rd_wr <= 1'b1;
            end
            dstb_n <= ~((state_d == ST_T2) || (state_d == ST_TW));
        end
    end

endmodule

// File: rtl/bus_cycle_ctrl.sv
module bus_cycle_ctrl
    import bcc_pkg::*;
#(
    parameter int WAIT_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [1:0]        req_size,
    input  logic              req_addr0,
    input  logic [WAIT_W-1:0] req_wait,
    output logic              ube_n,
    output logic              lbe_n,
    output logic              rd_wr,
    output logic              dstb_n,
    output logic              xfer_done
);

    bus_state_e state_q;
    bus_state_e state_d;
    logic       accept;
    logic       last;
    lane_en_t   lanes;

    bcc_seq #(.WAIT_W(WAIT_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_wait  (req_wait),
        .state_q   (state_q),
        .state_d   (state_d),
        .req_ready (req_ready),
        .accept    (accept),
        .last      (last)
    );

    bcc_lane_dec u_dec (
        .size  (req_size),
        .addr0 (req_addr0),
        .lanes (lanes)
    );

    bcc_out_reg u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .req_write (req_write),
        .lanes     (lanes),
        .state_d   (state_d),
        .ube_n     (ube_n),
        .lbe_n     (lbe_n),
        .rd_wr     (rd_wr),
        .dstb_n    (dstb_n)
    );

    assign xfer_done = last;

endmodule

// File: rtl/bcc_checker.sv
module bcc_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic       req_ready,
    input logic [1:0] req_size,
    input logic       ube_n,
    input logic       lbe_n,
    input logic       rd_wr,
    input logic       dstb_n,
    input logic       xfer_done
);

    a_r4_lanes_move_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({ube_n, lbe_n}) |-> $past(req_valid && req_ready));

    a_r5_rdwr_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_done && !req_valid) |=> rd_wr);

    a_r8_done_when_ready: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |-> req_ready);

    a_r6_strobe_high_t1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> dstb_n);

    a_r6_strobe_falls_after_t1: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dstb_n) |-> !$past(req_ready));

    a_r3_byte_one_lane: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_size == 2'b00) |=> (ube_n ^ lbe_n));

endmodule

bind bus_cycle_ctrl bcc_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_size  (req_size),
    .ube_n     (ube_n),
    .lbe_n     (lbe_n),
    .rd_wr     (rd_wr),
    .dstb_n    (dstb_n),
    .xfer_done (xfer_done)
);

// File: tb/bus_cycle_ctrl_bench.sv
module bus_cycle_ctrl_bench;

    localparam int WAIT_W = 3;

    typedef struct packed {
        logic       wr;
        logic [1:0] sz;
        logic       a0;
        logic [2:0] wt;
        logic       ube;
        logic       lbe;
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t VECS [NVEC] = '{
        '{wr: 1'b0, sz: 2'b00, a0: 1'b0, wt: 3'd0, ube: 1'b1, lbe: 1'b0},
        '{wr: 1'b1, sz: 2'b00, a0: 1'b1, wt: 3'd1, ube: 1'b0, lbe: 1'b1},
        '{wr: 1'b0, sz: 2'b01, a0: 1'b0, wt: 3'd2, ube: 1'b0, lbe: 1'b0},
        '{wr: 1'b1, sz: 2'b10, a0: 1'b0, wt: 3'd0, ube: 1'b0, lbe: 1'b0},
        '{wr: 1'b0, sz: 2'b00, a0: 1'b1, wt: 3'd7, ube: 1'b0, lbe: 1'b1},
        '{wr: 1'b1, sz: 2'b00, a0: 1'b0, wt: 3'd3, ube: 1'b1, lbe: 1'b0},
        '{wr: 1'b0, sz: 2'b11, a0: 1'b1, wt: 3'd1, ube: 1'b0, lbe: 1'b0},
        '{wr: 1'b1, sz: 2'b01, a0: 1'b1, wt: 3'd4, ube: 1'b0, lbe: 1'b0}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic              req_write = 1'b0;
    logic [1:0]        req_size = 2'b00;
    logic              req_addr0 = 1'b0;
    logic [WAIT_W-1:0] req_wait = '0;
    logic              ube_n, lbe_n, rd_wr, dstb_n, xfer_done;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    bus_cycle_ctrl #(.WAIT_W(WAIT_W)) u_bus_cycle_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_write (req_write),
        .req_size  (req_size),
        .req_addr0 (req_addr0),
        .req_wait  (req_wait),
        .ube_n     (ube_n),
        .lbe_n     (lbe_n),
        .rd_wr     (rd_wr),
        .dstb_n    (dstb_n),
        .xfer_done (xfer_done)
    );

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic drive(input vec_t v);
        req_write = v.wr;
        req_size  = v.sz;
        req_addr0 = v.a0;
        req_wait  = v.wt;
        req_valid = 1'b1;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        vec_t a;
        vec_t b;
        repeat (2) @(negedge clk);
        // R1: reset values
        chk("R1", "ube_n", ube_n, 1'b1);
        chk("R1", "lbe_n", lbe_n, 1'b1);
        chk("R1", "rd_wr", rd_wr, 1'b1);
        chk("R1", "dstb_n", dstb_n, 1'b1);
        chk("R1", "req_ready", req_ready, 1'b1);
        chk("R1", "xfer_done", xfer_done, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NVEC; i++) begin
            string lane_tag;
            lane_tag = (VECS[i].sz == 2'b00) ? "R3" : "R2";
            drive(VECS[i]);
            chk("R9", "ready in idle", req_ready, 1'b1);
            @(negedge clk);
            req_valid = 1'b0;
            // ST_T1
            chk(lane_tag, "ube_n", ube_n, VECS[i].ube);
            chk(lane_tag, "lbe_n", lbe_n, VECS[i].lbe);
            chk("R5", "rd_wr in T1", rd_wr, ~VECS[i].wr);
            chk("R6", "dstb_n in T1", dstb_n, 1'b1);
            chk("R9", "ready in T1", req_ready, 1'b0);
            for (int k = 0; k <= int'(VECS[i].wt); k++) begin
                @(negedge clk);
                chk("R6", "dstb_n in T2/TW", dstb_n, 1'b0);
                chk("R5", "rd_wr held", rd_wr, ~VECS[i].wr);
                chk("R8", "xfer_done", xfer_done, k == int'(VECS[i].wt));
                chk("R7", "ready at end only", req_ready, k == int'(VECS[i].wt));
            end
            @(negedge clk);
            chk("R6", "dstb_n idle", dstb_n, 1'b1);
            chk("R5", "rd_wr idle", rd_wr, 1'b1);
            chk("R8", "done idle", xfer_done, 1'b0);
            chk("R4", "ube_n held idle", ube_n, VECS[i].ube);
            chk("R4", "lbe_n held idle", lbe_n, VECS[i].lbe);
            @(negedge clk);
        end

        // R9/R10: request held off during a busy cycle, then taken in the final state
        a = '{wr: 1'b1, sz: 2'b00, a0: 1'b0, wt: 3'd2, ube: 1'b1, lbe: 1'b0};
        b = '{wr: 1'b0, sz: 2'b00, a0: 1'b1, wt: 3'd0, ube: 1'b0, lbe: 1'b1};
        drive(a);
        @(negedge clk);
        drive(b);
        chk("R9", "ready low in T1", req_ready, 1'b0);
        @(negedge clk);
        chk("R9", "ready low in T2", req_ready, 1'b0);
        chk("R9", "ube_n unchanged", ube_n, 1'b1);
        chk("R9", "lbe_n unchanged", lbe_n, 1'b0);
        chk("R9", "rd_wr unchanged", rd_wr, 1'b0);
        @(negedge clk);
        chk("R9", "ready low in first TW", req_ready, 1'b0);
        @(negedge clk);
        chk("R9", "ready in final TW", req_ready, 1'b1);
        chk("R8", "done in final TW", xfer_done, 1'b1);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R10", "dstb_n in new T1", dstb_n, 1'b1);
        chk("R10", "rd_wr read in new T1", rd_wr, 1'b1);
        chk("R10", "ube_n new", ube_n, 1'b0);
        chk("R10", "lbe_n new", lbe_n, 1'b1);
        chk("R10", "no done in T1", xfer_done, 1'b0);
        @(negedge clk);
        chk("R10", "dstb_n in T2", dstb_n, 1'b0);
        chk("R8", "done wait0", xfer_done, 1'b1);
        @(negedge clk);
        chk("R6", "dstb_n idle after", dstb_n, 1'b1);

        // R4: idle clocks with valid low leave lanes alone
        req_size  = 2'b10;
        req_addr0 = 1'b0;
        repeat (3) @(negedge clk);
        chk("R4", "ube_n idle hold", ube_n, 1'b0);
        chk("R4", "lbe_n idle hold", lbe_n, 1'b1);

        // R1: reset in the middle of a cycle
        drive(a);
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk("R1", "dstb_n on reset", dstb_n, 1'b1);
        chk("R1", "rd_wr on reset", rd_wr, 1'b1);
        chk("R1", "ube_n on reset", ube_n, 1'b1);
        chk("R1", "lbe_n on reset", lbe_n, 1'b1);
        chk("R1", "ready on reset", req_ready, 1'b1);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule